// File: doc/BRIEF.md
# Word-Serial AES-128 Encryption Round Sequencer

This block encrypts one 128-bit block with AES-128 using a single byte-slice round unit. Each call of that unit takes one byte from one state word and passes it through the S-box. In the middle rounds it also applies the column mix. It then rotates the result into place and XORs it into an accumulating output word. One slice runs per clock. A round is sixteen slices, which build the four output words one after another. The row shift of AES is never performed as a separate pass. It comes from the order in which source words are chosen: output word j draws byte k from source word (j+k) mod 4.

The block does not store any keys. A surrounding key store presents round key `rk_sel_o` on `rk_data_i` in the same cycle, with no register in that path. A run works as follows:

- A start pulse while idle captures the plaintext.
- The next cycle XORs in round key 0.
- Rounds 1 to 9 are middle rounds. Round 10 is the final round and skips the column mix.
- Each round's new state is committed only after all sixteen slices, so every slice of a round reads the same source words.
- A one-cycle done pulse then marks the ciphertext output as valid. The ciphertext stays on the output until the next run completes.

Top module: `aes_round_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy_o`=0, `done_o`=0, `rk_sel_o`=0 and `ct_o`=0.
- R2: A high `start_i` sampled at a rising edge while `busy_o`=0 captures `pt_i`. `busy_o` is 1 from the next cycle.
- R3: `start_i` and `pt_i` have no effect while `busy_o`=1. The running encryption and its result are unchanged.
- R4: In the cycle after acceptance (key addition), `rk_sel_o`=0. During the sixteen slice cycles of round r (r=1..10), `rk_sel_o`=r. While idle, `rk_sel_o`=0.
- R5: `done_o` is high for exactly one cycle, 161 rising edges after the accepting edge. `busy_o` is 0 in that same cycle, so a start in the done cycle is accepted.
- R6: `ct_o` equals the AES-128 encryption of the captured plaintext under the eleven supplied round keys. All 128-bit values use this encoding: bits [32j+31:32j] are column j, and bits [32j+8i+7:32j+8i] are row i of that column. Bytes are therefore stored low first.
- R7: Under the standard example key 000102..0f (byte order), the plaintext 00112233..ff gives the ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a (byte order).
- R8: `ct_o` changes only in the cycle in which `done_o` is high. In every other cycle it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to encrypt `pt_i` |
| pt_i | input | 128 | Plaintext, four little-endian column words |
| rk_sel_o | output | 4 | Index of the round key wanted this cycle |
| rk_data_i | input | 128 | Round key selected by `rk_sel_o`, same cycle |
| busy_o | output | 1 | Encryption in progress |
| done_o | output | 1 | One-cycle pulse marking a new ciphertext |
| ct_o | output | 128 | Ciphertext of the last completed run |

## Verification
After an accepting edge, `busy_o` is due one cycle later. `rk_sel_o` reads 0 for one cycle and then r for sixteen cycles in each round r. `done_o` and the new `ct_o` are due together, 161 edges after acceptance. The bench reference model steps on the same rising edges, using an elapsed-cycle counter and a behavioural encryption over byte arrays. Every output is compared with the model on the falling edge, where all registers on the path have settled. Separate checks repeat the 161-cycle latency by counting edges, and compare the fixed example vector against its known ciphertext.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_KEYADD = 2'd1,
    PH_ROUND  = 2'd2
  } seq_phase_e;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h00;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ p;
      p = gf_dbl(p);
    end
    return r;
  endfunction

  // multiplicative inverse as a^254 (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  // one byte slice: substitute byte bsel of src, optionally column-mix it,
  // rotate into row position bsel and fold into acc
  function automatic logic [31:0] slice_step(input logic [31:0] acc,
                                             input logic [31:0] src,
                                             input logic [1:0]  bsel,
                                             input logic        last);
    logic [7:0]  b;
    logic [7:0]  s;
    logic [31:0] mix;
    logic [31:0] rot;
    logic [5:0]  sh;
    sh  = {1'b0, bsel, 3'b000};
    b   = src[sh +: 8];
    s   = sbox_fwd(b);
    if (last) mix = {24'h0, s};
    else      mix = {gf_dbl(s) ^ s, s, s, gf_dbl(s)};
    rot = (mix << sh) | (mix >> (6'd32 - sh));
    return acc ^ rot;
  endfunction

endpackage

// File: rtl/aes_seq_ctrl.sv
module aes_seq_ctrl
  import aes_seq_pkg::*;
#(
  parameter  int NUM_ROUNDS = 10,
  parameter  int STEPS      = 16,
  localparam int RND_W      = $clog2(NUM_ROUNDS + 1),
  localparam int STEP_W     = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RND_W-1:0]  round_o,
  output logic [STEP_W-1:0] step_o,
  output logic              load_o,
  output logic              keyadd_o,
  output logic              step_fire_o,
  output logic              round_end_o,
  output logic              last_round_o,
  output logic              finish_o
);

  seq_phase_e        phase_q;
  logic [RND_W-1:0]  round_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;

  assign busy_o       = (phase_q != PH_IDLE);
  assign load_o       = (phase_q == PH_IDLE) && start_i;
  assign keyadd_o     = (phase_q == PH_KEYADD);
  assign step_fire_o  = (phase_q == PH_ROUND);
  assign round_end_o  = step_fire_o && (step_q == STEP_W'(STEPS - 1));
  assign last_round_o = (round_q == RND_W'(NUM_ROUNDS));
  assign finish_o     = round_end_o && last_round_o;
  assign done_o       = done_q;
  assign round_o      = round_q;
  assign step_o       = step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      round_q <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_KEYADD;
            round_q <= '0;
            step_q  <= '0;
          end
        end
        PH_KEYADD: begin
          phase_q <= PH_ROUND;
          round_q <= RND_W'(1);
          step_q  <= '0;
        end
        PH_ROUND: begin
          step_q <= step_q + 1'b1;
          if (round_end_o) begin
            step_q <= '0;
            if (last_round_o) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              round_q <= round_q + 1'b1;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && phase_q == PH_IDLE) |=> (phase_q == PH_KEYADD));

  // R3
  step_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire_o && !round_end_o) |=> (step_q == STEP_W'($past(step_q) + 1'b1)));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !finish_o) |=> busy_o);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/aes_word_pick.sv
module aes_word_pick #(
  parameter  int WORD_W    = 32,
  parameter  int NUM_WORDS = 4,
  localparam int BYTES     = WORD_W / 8,
  localparam int IDX_W     = $clog2(NUM_WORDS),
  localparam int SEL_W     = $clog2(BYTES),
  localparam int STEP_W    = IDX_W + SEL_W
) (
  input  logic [STEP_W-1:0]                 step_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  state_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  key_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  acc_i,
  output logic [IDX_W-1:0]                  dst_o,
  output logic [SEL_W-1:0]                  bsel_o,
  output logic                              first_o,
  output logic [WORD_W-1:0]                 src_o,
  output logic [WORD_W-1:0]                 seed_o
);

  logic [IDX_W-1:0] src_idx;

  assign dst_o   = step_i[STEP_W-1 -: IDX_W];
  assign bsel_o  = step_i[SEL_W-1:0];
  assign first_o = (bsel_o == '0);
  // rotating source choice stands in for the row shift
  assign src_idx = IDX_W'((int'(dst_o) + int'(bsel_o)) % NUM_WORDS);
  assign src_o   = state_i[src_idx];
  assign seed_o  = first_o ? key_i[dst_o] : acc_i[dst_o];

endmodule

// File: rtl/aes_slice_unit.sv
module aes_slice_unit
  import aes_seq_pkg::*;
(
  input  logic [31:0] acc_i,
  input  logic [31:0] src_i,
  input  logic [1:0]  bsel_i,
  input  logic        last_i,
  output logic [31:0] res_o
);

  assign res_o = slice_step(acc_i, src_i, bsel_i, last_i);

endmodule

// File: rtl/aes_round_sequencer.sv
module aes_round_sequencer
  import aes_seq_pkg::*;
#(
  parameter  int WORD_W     = 32,
  parameter  int NUM_WORDS  = 4,
  parameter  int NUM_ROUNDS = 10,
  localparam int BLOCK_W    = WORD_W * NUM_WORDS,
  localparam int BYTES      = WORD_W / 8,
  localparam int STEPS      = NUM_WORDS * BYTES,
  localparam int IDX_W      = $clog2(NUM_WORDS),
  localparam int SEL_W      = $clog2(BYTES),
  localparam int STEP_W     = $clog2(STEPS),
  localparam int RND_W      = $clog2(NUM_ROUNDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [BLOCK_W-1:0] pt_i,
  output logic [RND_W-1:0]   rk_sel_o,
  input  logic [BLOCK_W-1:0] rk_data_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [BLOCK_W-1:0] ct_o
);

  logic              busy, done, load, keyadd, step_fire, round_end, last_round, finish;
  logic [RND_W-1:0]  round;
  logic [STEP_W-1:0] step;

  logic [NUM_WORDS-1:0][WORD_W-1:0] state_q, nxt_q, ct_q, key_w, commit_w;
  logic [IDX_W-1:0]  dst;
  logic [SEL_W-1:0]  bsel;
  logic              first;
  logic [WORD_W-1:0] src_word, seed_word, slice_res;

  aes_seq_ctrl #(.NUM_ROUNDS(NUM_ROUNDS), .STEPS(STEPS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy),
    .done_o      (done),
    .round_o     (round),
    .step_o      (step),
    .load_o      (load),
    .keyadd_o    (keyadd),
    .step_fire_o (step_fire),
    .round_end_o (round_end),
    .last_round_o(last_round),
    .finish_o    (finish)
  );

  assign key_w = rk_data_i;

  aes_word_pick #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_pick (
    .step_i (step),
    .state_i(state_q),
    .key_i  (key_w),
    .acc_i  (nxt_q),
    .dst_o  (dst),
    .bsel_o (bsel),
    .first_o(first),
    .src_o  (src_word),
    .seed_o (seed_word)
  );

  aes_slice_unit u_slice (
    .acc_i (seed_word),
    .src_i (src_word),
    .bsel_i(bsel),
    .last_i(last_round),
    .res_o (slice_res)
  );

  // completed words of this round, with the word being finished this cycle
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_commit
    assign commit_w[w] = (dst == IDX_W'(w)) ? slice_res : nxt_q[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      nxt_q   <= '0;
      ct_q    <= '0;
    end else begin
      if (load) begin
        state_q <= pt_i;
      end else if (keyadd) begin
        state_q <= state_q ^ key_w;
      end else if (step_fire) begin
        nxt_q[dst] <= slice_res;
        if (round_end) state_q <= commit_w;
      end
      if (finish) ct_q <= commit_w;
    end
  end

  assign rk_sel_o = busy ? round : '0;
  assign busy_o   = busy;
  assign done_o   = done;
  assign ct_o     = ct_q;

  // R8
  ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(ct_o));

  // R4
  key0_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyadd |-> (rk_sel_o == '0));

  // R4
  rk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> (rk_sel_o != '0 && rk_sel_o <= RND_W'(NUM_ROUNDS)));

  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !keyadd && !round_end) |=> $stable(state_q));

  // R6
  first_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && first) |-> (seed_word == key_w[dst]));

endmodule

// File: tb/aes_round_sequencer_test.sv
module aes_round_sequencer_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] pt = '0;
  logic [3:0]   rk_sel;
  logic [127:0] rk_data;
  logic         busy, done;
  logic [127:0] ct;

  always #4 clk = ~clk;

  logic [7:0]   sb [256];
  logic [127:0] ks [11];

  assign rk_data = (rk_sel <= 4'd10) ? ks[rk_sel] : '0;

  aes_round_sequencer uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .pt_i     (pt),
    .rk_sel_o (rk_sel),
    .rk_data_i(rk_data),
    .busy_o   (busy),
    .done_o   (done),
    .ct_o     (ct)
  );

  int n_checks = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // S-box from the generator walk: p steps by 3, q by 1/3
  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ xt(p);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  task automatic load_key(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[32*i +: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[7:0], t[31:8]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
        t = t ^ {24'h0, rc};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) ks[r] = {w[4*r+3], w[4*r+2], w[4*r+1], w[4*r]};
  endtask

  function automatic logic [127:0] ref_encrypt(input logic [127:0] p);
    logic [7:0] st [16];
    logic [7:0] tp [16];
    logic [7:0] a0, a1, a2, a3;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) st[i] = p[8*i +: 8] ^ ks[0][8*i +: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) st[i] = sb[st[i]];
      for (int c = 0; c < 4; c++)
        for (int row = 0; row < 4; row++)
          tp[c*4+row] = st[((c + row) % 4)*4 + row];
      for (int i = 0; i < 16; i++) st[i] = tp[i];
      if (r < 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = st[c*4]; a1 = st[c*4+1]; a2 = st[c*4+2]; a3 = st[c*4+3];
          st[c*4]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          st[c*4+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          st[c*4+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          st[c*4+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
      end
      for (int i = 0; i < 16; i++) st[i] = st[i] ^ ks[r][8*i +: 8];
    end
    for (int i = 0; i < 16; i++) res[8*i +: 8] = st[i];
    return res;
  endfunction

  // cycle model
  bit           m_busy;
  int           m_cnt;
  bit           m_done;
  logic [127:0] m_ct, m_pend;
  bit           cmp_en = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_cnt <= 0; m_done <= 1'b0; m_ct <= '0; m_pend <= '0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy) begin
        if (start) begin
          m_busy <= 1'b1;
          m_cnt  <= 0;
          m_pend <= ref_encrypt(pt);
        end
      end else begin
        m_cnt <= m_cnt + 1;
        if (m_cnt == 160) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
          m_ct   <= m_pend;
        end
      end
    end
  end

  function automatic logic [3:0] exp_sel();
    if (!m_busy || m_cnt == 0) return 4'd0;
    return 4'((m_cnt - 1) / 16 + 1);
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(busy == m_busy, "R2", 128'(busy), 128'(m_busy));
      chk(done == m_done, "R5", 128'(done), 128'(m_done));
      chk(rk_sel == exp_sel(), "R4", 128'(rk_sel), 128'(exp_sel()));
      chk(ct == m_ct, "R8", ct, m_ct);
    end
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  // returns the number of falling edges waited after start was dropped
  task automatic wait_done(output int lat);
    lat = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin
        lat = i;
        return;
      end
    end
    chk(1'b0, "R5", 128'(0), 128'(1));
  endtask

  task automatic run(input logic [127:0] p, output int lat);
    @(negedge clk);
    start = 1'b1; pt = p;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
  endtask

  localparam logic [127:0] FIPS_KEY = {32'h0f0e0d0c, 32'h0b0a0908, 32'h07060504, 32'h03020100};
  localparam logic [127:0] FIPS_PT  = {32'hffeeddcc, 32'hbbaa9988, 32'h77665544, 32'h33221100};
  localparam logic [127:0] FIPS_CT  = {32'h5ac5b470, 32'h80b7cdd8, 32'h30047b6a, 32'hd8e0c469};

  initial begin
    int lat;
    logic [127:0] p0, kk;
    build_sbox();
    load_key(FIPS_KEY);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(busy == 1'b0, "R1", 128'(busy), 128'(0));
    chk(done == 1'b0, "R1", 128'(done), 128'(0));
    chk(ct == '0, "R1", ct, '0);
    chk(rk_sel == 4'd0, "R1", 128'(rk_sel), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && ct == '0, "R1", {busy, done, ct[125:0]}, '0);
    cmp_en = 1'b1;

    // R7 known vector, R5 latency
    run(FIPS_PT, lat);
    chk(ct == FIPS_CT, "R7", ct, FIPS_CT);
    chk(lat == 160, "R5", 128'(lat), 128'(160));
    chk(ct == ref_encrypt(FIPS_PT), "R6", ct, ref_encrypt(FIPS_PT));

    // R3: start held with other plaintext while busy
    p0 = {4{32'h01234567}};
    @(negedge clk);
    start = 1'b1; pt = p0;
    @(negedge clk);
    pt = ~p0;
    repeat (60) @(negedge clk);
    pt = '1;
    repeat (20) @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk(ct == ref_encrypt(p0), "R3", ct, ref_encrypt(p0));

    // R6 corner vectors and random vectors
    run('0, lat);
    chk(ct == ref_encrypt('0), "R6", ct, ref_encrypt('0));
    load_key('1);
    run('1, lat);
    chk(ct == ref_encrypt('1), "R6", ct, ref_encrypt('1));
    for (int n = 0; n < 6; n++) begin
      kk = {$urandom, $urandom, $urandom, $urandom};
      p0 = {$urandom, $urandom, $urandom, $urandom};
      load_key(kk);
      run(p0, lat);
      chk(ct == ref_encrypt(p0), "R6", ct, ref_encrypt(p0));
    end

    // R5 back-to-back: start held through the done cycle is accepted there
    p0 = {32'hdeadbeef, 32'h0badf00d, 32'hcafebabe, 32'h12345678};
    @(negedge clk);
    start = 1'b1; pt = p0;
    @(negedge clk);
    wait_done(lat);
    chk(lat == 160, "R5", 128'(lat), 128'(160));
    pt = ~p0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R5", 128'(busy), 128'(1));
    wait_done(lat);
    chk(ct == ref_encrypt(~p0), "R6", ct, ref_encrypt(~p0));
    repeat (5) @(negedge clk);
    chk(ct == ref_encrypt(~p0), "R8", ct, ref_encrypt(~p0));

    finish_sim();
  end

endmodule